// File: doc/BRIEF.md
# Two-Channel DMA Transfer Controller

This block moves data between memory and I/O locations on behalf of a host. It has two channels. Each channel has four registers on a simple register bus: a 16-bit mode word, a source pointer, a destination pointer and a transfer count. A started channel asks for service. An arbiter picks one requesting channel, and a single transfer engine then carries out one transfer on a memory master bus: a read from the channel's source pointer, then a write of that data to its destination pointer. Pointers and count are then updated.

A channel's service requests follow its pacing mode. Free-running channels ask whenever they are started. Source-paced and destination-paced channels ask only while their request line is high. The request line is either the channel's external pin or, in source-paced mode only, its internal request input. A channel can stop when the count reaches zero and can then raise an interrupt. A per-channel urgency bit decides between channels. Channels of equal urgency take turns.

Register map: `reg_addr[2]` selects the channel. `reg_addr[1:0]` selects 0 mode word, 1 source pointer, 2 destination pointer, 3 count. Read data appears on `reg_rdata` one cycle after `reg_addr` is presented.

Mode word bits: 0 `wide` (1 = 16-bit transfers, 0 = byte), 1 `run`, 2 `arm`, 3 `irq_en`, 4 `tc_stop`, 5 `urgent`, 6 `int_sel`, 8:7 `pace`, 9 `src_io`, 10 `src_up`, 11 `src_down`, 12 `dst_io`, 13 `dst_up`, 14 `dst_down`, 15 reserved.

Top module: `dual_dma_engine`

## Requirements
- R1: In a mode-word write, bit 15 (reserved) and bit 2 (`arm`) are not stored and read back as 0. The other fields read back exactly as written, except `run` (see R2). After reset every register reads 0, and `mem_req` and `irq` are 0.
- R2: `run` (bit 1) takes the written value only when `arm` (bit 2) is 1 in the same write. Otherwise `run` keeps its value, and no transfer starts.
- R3: `pace` (bits 8:7) selects how requests are paced. 00 is free-running: the channel requests whenever `run` is set. 01 is source-paced and 10 is destination-paced: the channel requests only while its request line is 1. 11 is reserved: the channel never requests.
- R4: With `int_sel` (bit 6) set, the request line is `int_dreq[ch]` and `ext_dreq[ch]` is ignored. The channel requests only if `pace` is 01. With any other `pace` value it never requests.
- R5: A transfer first reads at the source pointer with `mem_we`=0. It then writes the read data at the destination pointer with `mem_we`=1. `mem_io` gives the `src_io` or `dst_io` bit for each phase, and `mem_wide` gives `wide`. `mem_req`, `mem_we` and `mem_addr` hold until `mem_ack`.
- R6: After each transfer, each pointer steps by 2 when `wide` is 1 and by 1 when `wide` is 0. It moves up if only its up bit is set, down if only its down bit is set, and holds if both or neither are set.
- R7: The count decrements by 1 per transfer. Terminal count is the count becoming 0. A start from count 0 allows 65536 transfers.
- R8: With `tc_stop` set, `run` clears at terminal count. In paced modes with `tc_stop` clear, the channel keeps running past zero.
- R9: In free-running mode, `run` clears at terminal count whatever `tc_stop` holds.
- R10: `irq[ch]` sets at terminal count only if both `irq_en` and `tc_stop` are set. It stays set until the next mode-word write to that channel.
- R11: When both channels request and exactly one has `urgent` (bit 5) set, that channel is served.
- R12: Requesting channels of equal urgency are served alternately, one transfer each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: channel and register |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data, one cycle after address |
| ext_dreq | input | 2 | External request pin per channel |
| int_dreq | input | 2 | Internal request line per channel |
| mem_req | output | 1 | Memory bus request, held until acknowledge |
| mem_we | output | 1 | 1 = write phase, 0 = read phase |
| mem_io | output | 1 | 1 = I/O space, 0 = memory space |
| mem_wide | output | 1 | 1 = 16-bit access, 0 = byte access |
| mem_addr | output | 16 | Memory bus address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access completed this cycle |
| irq | output | 2 | Terminal-count interrupt per channel |

## Verification
A wrong pointer shows on `mem_addr` in the request cycle of the channel's next transfer. It also shows in a register read one cycle after the address. A wrong count or `run` state shows as a missing or extra write transaction a few cycles after the expected last one. It also shows as a `run` bit that differs on readback. A fault in the arbiter shows in the order of destination addresses across the write phases of interleaved transfers, from the very first grant.

// File: rtl/ddma_pkg.sv
package ddma_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    PACE_FREE = 2'b00,
    PACE_SRC  = 2'b01,
    PACE_DST  = 2'b10,
    PACE_BAD  = 2'b11
  } pace_e;

  typedef struct packed {
    logic  rsvd;
    logic  dst_down;
    logic  dst_up;
    logic  dst_io;
    logic  src_down;
    logic  src_up;
    logic  src_io;
    pace_e pace;
    logic  int_sel;
    logic  urgent;
    logic  tc_stop;
    logic  irq_en;
    logic  arm;
    logic  run;
    logic  wide;
  } mode_t;

  typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_WR, MV_DONE} mv_state_e;
endpackage

// File: rtl/ddma_channel.sv
module ddma_channel
  import ddma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_mode,
  input  logic               wr_src,
  input  logic               wr_dst,
  input  logic               wr_cnt,
  input  logic [REG_W-1:0]   wdata,
  input  logic               ext_dreq,
  input  logic               int_dreq,
  input  logic               done,
  output mode_t              mode_q,
  output logic [AW-1:0]      src_q,
  output logic [AW-1:0]      dst_q,
  output logic [CW-1:0]      cnt_q,
  output logic               req,
  output logic               irq_q
);
  mode_t         wr_word, mode_nx;
  logic [AW-1:0] s_step, d_step, src_nx, dst_nx;
  logic [CW-1:0] cnt_nx;
  logic          hit_tc, stop_now, line, want;

  assign wr_word = mode_t'(wdata);

  always_comb begin
    s_step = mode_q.wide ? AW'(2) : AW'(1);
    d_step = s_step;
    src_nx = src_q;
    if (mode_q.src_up && !mode_q.src_down)      src_nx = src_q + s_step;
    else if (mode_q.src_down && !mode_q.src_up) src_nx = src_q - s_step;
    dst_nx = dst_q;
    if (mode_q.dst_up && !mode_q.dst_down)      dst_nx = dst_q + d_step;
    else if (mode_q.dst_down && !mode_q.dst_up) dst_nx = dst_q - d_step;
    cnt_nx   = cnt_q - CW'(1);
    hit_tc   = (cnt_nx == '0);
    stop_now = hit_tc && (mode_q.tc_stop || mode_q.pace == PACE_FREE);
  end

  always_comb begin
    mode_nx       = wr_word;
    mode_nx.rsvd  = 1'b0;
    mode_nx.arm   = 1'b0;
    mode_nx.run   = wr_word.arm ? wr_word.run : (mode_q.run && !(done && stop_now));
  end

  always_comb begin
    line = mode_q.int_sel ? int_dreq : ext_dreq;
    case (mode_q.pace)
      PACE_FREE: want = !mode_q.int_sel;
      PACE_SRC:  want = line;
      PACE_DST:  want = !mode_q.int_sel && ext_dreq;
      default:   want = 1'b0;
    endcase
    req = mode_q.run && want;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (done) begin
        src_q <= src_nx;
        dst_q <= dst_nx;
        cnt_q <= cnt_nx;
        if (stop_now) mode_q.run <= 1'b0;
        if (hit_tc && mode_q.tc_stop && mode_q.irq_en) irq_q <= 1'b1;
      end
      if (wr_src) src_q <= AW'(wdata);
      if (wr_dst) dst_q <= AW'(wdata);
      if (wr_cnt) cnt_q <= CW'(wdata);
      if (wr_mode) begin
        mode_q <= mode_nx;
        irq_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ddma_arbiter.sv
module ddma_arbiter #(
  parameter int NCH = 2,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] urgent,
  input  logic           advance,
  output logic [NCH-1:0] grant_oh,
  output logic [IW-1:0]  grant_idx,
  output logic           grant_any
);
  logic [IW-1:0]  last_r;
  logic [NCH-1:0] pool;
  logic           hi_any;

  always_comb begin
    int cand;
    cand      = 0;
    hi_any    = |(req & urgent);
    pool      = hi_any ? (req & urgent) : req;
    grant_any = 1'b0;
    grant_idx = '0;
    for (int k = 1; k <= NCH; k++) begin
      cand = (int'(last_r) + k) % NCH;
      if (!grant_any && pool[cand[IW-1:0]]) begin
        grant_any = 1'b1;
        grant_idx = cand[IW-1:0];
      end
    end
    grant_oh = grant_any ? (NCH'(1) << grant_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          last_r <= IW'(NCH - 1);
    else if (advance) last_r <= grant_idx;
  end
endmodule

// File: rtl/ddma_mover.sv
module ddma_mover
  import ddma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 16,
  parameter int DW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           grant_any,
  input  logic [IW-1:0]  grant_idx,
  input  logic [AW-1:0]  g_src,
  input  logic [AW-1:0]  g_dst,
  input  logic           g_src_io,
  input  logic           g_dst_io,
  input  logic           g_wide,
  output logic           accept,
  output logic [NCH-1:0] done_oh,
  output logic           mem_req,
  output logic           mem_we,
  output logic           mem_io,
  output logic           mem_wide,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack
);
  mv_state_e     state;
  logic [IW-1:0] owner;
  logic [AW-1:0] dst_hold;
  logic          dst_io_hold;

  assign accept = (state == MV_IDLE) && grant_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= MV_IDLE;
      owner       <= '0;
      dst_hold    <= '0;
      dst_io_hold <= 1'b0;
      done_oh     <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_io      <= 1'b0;
      mem_wide    <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      done_oh <= '0;
      case (state)
        MV_IDLE: if (grant_any) begin
          owner       <= grant_idx;
          dst_hold    <= g_dst;
          dst_io_hold <= g_dst_io;
          mem_req     <= 1'b1;
          mem_we      <= 1'b0;
          mem_addr    <= g_src;
          mem_io      <= g_src_io;
          mem_wide    <= g_wide;
          state       <= MV_RD;
        end
        MV_RD: if (mem_ack) begin
          mem_wdata <= mem_rdata;
          mem_we    <= 1'b1;
          mem_addr  <= dst_hold;
          mem_io    <= dst_io_hold;
          state     <= MV_WR;
        end
        MV_WR: if (mem_ack) begin
          mem_req        <= 1'b0;
          mem_we         <= 1'b0;
          done_oh[owner] <= 1'b1;
          state          <= MV_DONE;
        end
        MV_DONE: state <= MV_IDLE;
        default: state <= MV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_dma_engine.sv
module dual_dma_engine
  import ddma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int DW  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic [$clog2(NCH)+1:0]  reg_addr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  input  logic [NCH-1:0]          ext_dreq,
  input  logic [NCH-1:0]          int_dreq,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic                    mem_io,
  output logic                    mem_wide,
  output logic [AW-1:0]           mem_addr,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata,
  input  logic                    mem_ack,
  output logic [NCH-1:0]          irq
);
  localparam int CHW = $clog2(NCH);
  localparam int RA  = CHW + 2;
  localparam int IW  = (NCH > 1) ? CHW : 1;

  mode_t          mode_q [NCH];
  logic [AW-1:0]  src_q  [NCH];
  logic [AW-1:0]  dst_q  [NCH];
  logic [CW-1:0]  cnt_q  [NCH];
  logic [NCH-1:0] chan_req, chan_urgent, grant_oh, done_oh;
  logic [IW-1:0]  grant_idx;
  logic           grant_any, accept;
  logic [CHW-1:0] rch;
  logic [1:0]     rsel;

  assign rch  = reg_addr[RA-1:2];
  assign rsel = reg_addr[1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit            = reg_we && (rch == CHW'(i));
    assign chan_urgent[i] = mode_q[i].urgent;

    ddma_channel #(.AW(AW), .CW(CW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_mode  (hit && rsel == 2'd0),
      .wr_src   (hit && rsel == 2'd1),
      .wr_dst   (hit && rsel == 2'd2),
      .wr_cnt   (hit && rsel == 2'd3),
      .wdata    (reg_wdata),
      .ext_dreq (ext_dreq[i]),
      .int_dreq (int_dreq[i]),
      .done     (done_oh[i]),
      .mode_q   (mode_q[i]),
      .src_q    (src_q[i]),
      .dst_q    (dst_q[i]),
      .cnt_q    (cnt_q[i]),
      .req      (chan_req[i]),
      .irq_q    (irq[i])
    );
  end

  ddma_arbiter #(.NCH(NCH)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .req       (chan_req),
    .urgent    (chan_urgent),
    .advance   (accept),
    .grant_oh  (grant_oh),
    .grant_idx (grant_idx),
    .grant_any (grant_any)
  );

  ddma_mover #(.NCH(NCH), .AW(AW), .DW(DW)) u_mv (
    .clk       (clk),
    .rst       (rst),
    .grant_any (grant_any),
    .grant_idx (grant_idx),
    .g_src     (src_q[grant_idx]),
    .g_dst     (dst_q[grant_idx]),
    .g_src_io  (mode_q[grant_idx].src_io),
    .g_dst_io  (mode_q[grant_idx].dst_io),
    .g_wide    (mode_q[grant_idx].wide),
    .accept    (accept),
    .done_oh   (done_oh),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_io    (mem_io),
    .mem_wide  (mem_wide),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (int'(rch) < NCH) begin
      case (rsel)
        2'd0:    reg_rdata <= REG_W'(mode_q[rch]);
        2'd1:    reg_rdata <= REG_W'(src_q[rch]);
        2'd2:    reg_rdata <= REG_W'(dst_q[rch]);
        default: reg_rdata <= REG_W'(cnt_q[rch]);
      endcase
    end else begin
      reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/ddma_checker.sv
module ddma_checker #(
  parameter int NCH = 2,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_ack,
  input logic [AW-1:0]  mem_addr,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] chan_req,
  input logic [NCH-1:0] chan_urgent,
  input logic [NCH-1:0] grant_oh,
  input logic           grant_any
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_we)));

  // R5
  we_in_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

  // R11
  urgent_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_any && |(chan_req & chan_urgent)) |-> |(grant_oh & chan_urgent));

  // R12
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_oh) && ((grant_oh & ~chan_req) == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_irq
    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[i]) |-> $past(mem_ack && mem_we, 2));
  end
endmodule

bind dual_dma_engine ddma_checker #(.NCH(NCH), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr),
  .irq         (irq),
  .chan_req    (chan_req),
  .chan_urgent (chan_urgent),
  .grant_oh    (grant_oh),
  .grant_any   (grant_any)
);

// File: tb/dual_dma_engine_bench.sv
module dual_dma_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  ext_dreq = '0;
  logic [1:0]  int_dreq = '0;
  logic        mem_req, mem_we, mem_io, mem_wide;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack;
  logic [1:0]  irq;

  always #2 clk = ~clk;

  dual_dma_engine u_dual_dma_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_dreq(ext_dreq),
    .int_dreq(int_dreq), .mem_req(mem_req), .mem_we(mem_we), .mem_io(mem_io),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
  );

  // memory model
  logic [15:0] mem [1024];
  logic [15:0] wl_addr [64];
  logic [15:0] wl_data [64];
  logic        wl_io   [64];
  logic        wl_wide [64];
  int          nwr = 0;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return (a * 16'd3) ^ 16'h5A3C;
  endfunction

  initial for (int i = 0; i < 1024; i++) mem[i] = pat(16'(i));

  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else     mem_ack <= mem_req && !mem_ack;
    if (!rst && mem_req && mem_we && mem_ack) begin
      mem[mem_addr[9:0]] <= mem_wdata;
      wl_addr[nwr % 64]  <= mem_addr;
      wl_data[nwr % 64]  <= mem_wdata;
      wl_io[nwr % 64]    <= mem_io;
      wl_wide[nwr % 64]  <= mem_wide;
      nwr <= nwr + 1;
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_writes(input int target, input string tag);
    int t;
    t = 0;
    while (nwr < target && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (10) @(negedge clk);
    chk(tag, nwr, target);
  endtask

  task automatic idle_window(input string tag);
    int b;
    b = nwr;
    repeat (30) @(negedge clk);
    chk(tag, nwr - b, 0);
  endtask

  // ctrl, src, dst, cnt, final src, final dst, last src, last dst
  localparam logic [127:0] VEC [4] = '{
    {16'h2407, 16'h0100, 16'h0200, 16'd3, 16'h0106, 16'h0206, 16'h0104, 16'h0204},
    {16'h0806, 16'h0150, 16'h0300, 16'd4, 16'h014C, 16'h0300, 16'h014D, 16'h0300},
    {16'h4C07, 16'h0180, 16'h0400, 16'd2, 16'h0180, 16'h03FC, 16'h0180, 16'h03FE},
    {16'h3406, 16'h01A0, 16'h0010, 16'd5, 16'h01A5, 16'h0015, 16'h01A4, 16'h0014}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rv;
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 reset mem_req", mem_req, 0);
    chk("R1 reset irq", irq, 0);
    rd(3'd0, rv); chk("R1 reset mode ch0", rv, 16'h0000);
    rd(3'd7, rv); chk("R1 reset count ch1", rv, 16'h0000);

    // vector table: free-running channel 0 runs
    for (int v = 0; v < 4; v++) begin
      logic [15:0] c, s, d, n, fs, fd, ls, ld;
      {c, s, d, n, fs, fd, ls, ld} = VEC[v];
      base = nwr;
      wr(3'd1, s); wr(3'd2, d); wr(3'd3, n);
      wr(3'd0, c);
      wait_writes(base + int'(n), "R9 free-running transfer total");
      rd(3'd1, rv); chk("R6 final source pointer", rv, fs);
      rd(3'd2, rv); chk("R6 final destination pointer", rv, fd);
      rd(3'd3, rv); chk("R7 count at terminal", rv, 16'h0000);
      rd(3'd0, rv); chk("R9 run cleared, R1 readback", rv, c & 16'hFFF9);
      chk("R5 last write address", wl_addr[(nwr - 1) % 64], ld);
      chk("R5 last write data", wl_data[(nwr - 1) % 64], pat(ls));
      chk("R5 write io space", wl_io[(nwr - 1) % 64], c[12]);
      chk("R5 write width", wl_wide[(nwr - 1) % 64], c[0]);
    end

    // R1 reserved and arm bits
    wr(3'd0, 16'h8000);
    rd(3'd0, rv); chk("R1 reserved bit reads zero", rv, 16'h0000);
    wr(3'd0, 16'h7FFB);
    rd(3'd0, rv); chk("R1 fields stored, arm zero", rv, 16'h7FF9);
    wr(3'd0, 16'h0000);

    // R2 run needs arm
    wr(3'd1, 16'h0100); wr(3'd2, 16'h0220); wr(3'd3, 16'd2);
    wr(3'd0, 16'h2403);
    idle_window("R2 no start without arm");
    rd(3'd0, rv); chk("R2 run unchanged", rv, 16'h2401);
    base = nwr;
    wr(3'd0, 16'h2407);
    wait_writes(base + 2, "R2 start with arm");

    // R3 reserved pace
    wr(3'd3, 16'd3);
    wr(3'd0, 16'h0186);
    idle_window("R3 reserved pace never requests");
    rd(3'd0, rv); chk("R3 run set but idle", rv, 16'h0182);
    wr(3'd0, 16'h0004);

    // R3 source-paced from pin, R8 stop, R10 interrupt
    wr(3'd1, 16'h0120); wr(3'd2, 16'h0230); wr(3'd3, 16'd2);
    wr(3'd0, 16'h249F);
    idle_window("R3 paced waits for pin");
    rd(3'd3, rv); chk("R3 count untouched while idle", rv, 16'd2);
    base = nwr;
    @(negedge clk); ext_dreq = 2'b01;
    wait_writes(base + 2, "R8 stop at terminal count");
    chk("R10 irq at terminal count", irq, 2'b01);
    rd(3'd0, rv); chk("R8 run cleared", rv[1], 1'b0);
    ext_dreq = 2'b00;
    wr(3'd0, 16'h0000);
    chk("R10 irq cleared by mode write", irq, 2'b00);

    // R4 internal request select
    wr(3'd3, 16'd1);
    wr(3'd0, 16'h24DF);
    @(negedge clk); ext_dreq = 2'b01;
    idle_window("R4 pin ignored with internal select");
    base = nwr;
    int_dreq = 2'b01;
    wait_writes(base + 1, "R4 internal line serves");
    ext_dreq = 2'b00; int_dreq = 2'b00;
    wr(3'd3, 16'd1);
    wr(3'd0, 16'h2557);
    @(negedge clk); ext_dreq = 2'b01; int_dreq = 2'b01;
    idle_window("R4 internal select illegal with dest pacing");
    ext_dreq = 2'b00; int_dreq = 2'b00;
    wr(3'd0, 16'h0004);

    // R8 paced without tc_stop continues past zero
    wr(3'd1, 16'h0130); wr(3'd2, 16'h0240); wr(3'd3, 16'd1);
    wr(3'd0, 16'h248F);
    base = nwr;
    @(negedge clk); ext_dreq = 2'b01;
    for (int t = 0; t < 3000 && nwr < base + 3; t++) @(negedge clk);
    ext_dreq = 2'b00;
    repeat (12) @(negedge clk);
    chk("R8 continued past zero", (nwr - base) >= 3, 1);
    rd(3'd0, rv); chk("R8 run still set", rv, 16'h248B);
    chk("R10 no irq without tc_stop", irq, 2'b00);
    wr(3'd0, 16'h0004);
    repeat (10) @(negedge clk);

    // R9 free-running stops; R10 irq_en without tc_stop
    wr(3'd3, 16'd1);
    base = nwr;
    wr(3'd0, 16'h240F);
    wait_writes(base + 1, "R9 free-running stops without tc_stop");
    rd(3'd0, rv); chk("R9 run cleared", rv[1], 1'b0);
    chk("R10 irq_en alone gives no irq", irq, 2'b00);

    // R11 urgency
    wr(3'd1, 16'h0100); wr(3'd2, 16'h0280); wr(3'd3, 16'd3);
    wr(3'd5, 16'h0160); wr(3'd6, 16'h0380); wr(3'd7, 16'd3);
    wr(3'd0, 16'h249F);
    wr(3'd4, 16'h24BF);
    base = nwr;
    @(negedge clk); ext_dreq = 2'b11;
    wait_writes(base + 6, "R11 both channels complete");
    for (int k = 0; k < 6; k++)
      chk("R11 urgent channel served first", wl_addr[(base + k) % 64][9:8], (k < 3) ? 2'd3 : 2'd2);
    ext_dreq = 2'b00;

    // R12 equal urgency alternates
    wr(3'd1, 16'h0100); wr(3'd2, 16'h0290); wr(3'd3, 16'd3);
    wr(3'd5, 16'h0160); wr(3'd6, 16'h0390); wr(3'd7, 16'd3);
    wr(3'd0, 16'h249F);
    wr(3'd4, 16'h249F);
    base = nwr;
    @(negedge clk); ext_dreq = 2'b11;
    wait_writes(base + 6, "R12 both channels complete");
    for (int k = 0; k < 5; k++)
      chk("R12 alternating service", wl_addr[(base + k) % 64][8] != wl_addr[(base + k + 1) % 64][8], 1);
    ext_dreq = 2'b00;

    summary();
    $finish;
  end
endmodule